// File: doc/BRIEF.md
# Vector Tree Reduction Sequencer

This block adds up an arbitrarily long stream of integers. Each transfer delivers a chunk of `LANES` elements. The block keeps one running partial sum per lane. A lane-wise add folds each chunk into these partial sums, so the accumulation has no serial carried dependence from one element to the next.

When the chunk flagged as last has been taken, the block stops accepting input and collapses the partial sums with a halving tree. On every fold cycle, each lane in the lower half of the live range takes the sum of itself and its partner in the upper half. The live range then shrinks by half. After `log2(LANES)` folds, lane 0 holds the total. The block presents that total for one cycle, clears every lane, and reopens its input for the next stream.

The controller has three states:
- `ST_GATHER`: accepts chunks while `in_ready` is high.
- `ST_FOLD`: performs one halving step per cycle.
- `ST_EMIT`: presents the result and clears the lanes.

Its transitions are:
- GATHER→FOLD on a handshake with `in_last` set.
- FOLD→FOLD while fold steps remain.
- FOLD→EMIT on the final fold.
- EMIT→GATHER unconditionally.
- Any state → GATHER on reset.

Top module: `vec_tree_reducer`

## Requirements
- R1: After reset, `in_ready` is 1 and `sum_valid` is 0, and all partial sums are zero. A reset that arrives in the middle of a fold abandons that stream.
- R2: `sum_data` equals the sum of every element of every chunk of the stream. Element `i` of a chunk occupies bits `[i*ELEM_W +: ELEM_W]` of `in_data`.
- R3: `sum_valid` rises exactly `log2(LANES)` clock cycles after the clock edge that accepts the last chunk (`in_valid & in_ready & in_last`).
- R4: `in_ready` is 0 from the cycle after the last chunk is accepted until `sum_valid` has been high. It returns to 1 in the cycle right after the `sum_valid` pulse.
- R5: A chunk presented while `in_ready` is 0 is ignored and does not change the result.
- R6: A stream made of a single chunk gives the correct sum.
- R7: Every stream starts from zero partial sums, so consecutive streams do not contaminate each other.
- R8: Addition wraps modulo 2^`ELEM_W`.
- R9: `sum_valid` is a one-cycle pulse per stream.
- R10: Idle cycles between chunks, where `in_valid` is 0, leave the partial sums unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chunk present |
| in_last | input | 1 | Chunk is the final one of the stream |
| in_data | input | LANES*ELEM_W | Chunk elements, lane 0 in the low bits |
| in_ready | output | 1 | Block accepts a chunk this cycle |
| sum_valid | output | 1 | One-cycle result strobe |
| sum_data | output | ELEM_W | Stream total, meaningful while `sum_valid` is high |

## Verification
The hardest cases to reach are the ones where the fold tree is busy:
- a chunk offered during the fold phase;
- a reset landing part-way through the fold;
- a new stream arriving immediately after a result.

To reach them, the stimulus keeps `in_valid` high with large junk data for the whole fold window. It then pulses reset two cycles into a fold and runs a single-chunk stream right afterwards. That stream's sum would expose any leftover partial sums. The wrap case uses all-ones elements, so every lane overflows during both accumulation and folding.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_FOLD   = 2'd1,
        ST_EMIT   = 2'd2
    } vtr_state_e;

    typedef enum logic [1:0] {
        LOP_HOLD  = 2'd0,
        LOP_CLEAR = 2'd1,
        LOP_ADD   = 2'd2,
        LOP_FOLD  = 2'd3
    } lane_op_e;
endpackage

// File: rtl/vtr_ctrl.sv
module vtr_ctrl
    import vtr_pkg::*;
#(
    parameter int STEPS = 3,
    localparam int SW = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic          sum_valid,
    output lane_op_e      lane_op,
    output logic [SW-1:0] fold_idx
);
    vtr_state_e state_q, state_d;
    logic [SW-1:0] step_q;

    // state register and fold step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= (state_q == ST_FOLD) ? step_q + 1'b1 : '0;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (in_valid && in_last) state_d = ST_FOLD;
            ST_FOLD:   if (step_q == SW'(STEPS - 1)) state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_GATHER;
            default:   state_d = ST_GATHER;
        endcase
    end

    // outputs per state
    always_comb begin
        in_ready  = 1'b0;
        sum_valid = 1'b0;
        lane_op   = LOP_HOLD;
        unique case (state_q)
            ST_GATHER: begin
                in_ready = 1'b1;
                lane_op  = in_valid ? LOP_ADD : LOP_HOLD;
            end
            ST_FOLD:  lane_op = LOP_FOLD;
            ST_EMIT: begin
                sum_valid = 1'b1;
                lane_op   = LOP_CLEAR;
            end
            default:  lane_op = LOP_HOLD;
        endcase
    end

    assign fold_idx = step_q;
endmodule

// File: rtl/vtr_lane_bank.sv
module vtr_lane_bank
    import vtr_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 32,
    parameter int SW     = 2,
    localparam int IW = $clog2(LANES),
    localparam int HW = IW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lane_op_e                  lane_op,
    input  logic [SW-1:0]             fold_idx,
    input  logic [LANES*ELEM_W-1:0]   chunk,
    output logic [ELEM_W-1:0]         lane0
);
    logic [ELEM_W-1:0] elem  [LANES];
    logic [ELEM_W-1:0] acc_q [LANES];
    logic [ELEM_W-1:0] acc_d [LANES];
    logic [HW-1:0]     half;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign elem[g] = chunk[g*ELEM_W +: ELEM_W];
    end

    // live range after this fold: LANES >> (step+1)
    assign half = HW'(LANES >> (32'(fold_idx) + 32'd1));

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            acc_d[i] = acc_q[i];
            unique case (lane_op)
                LOP_HOLD:  acc_d[i] = acc_q[i];
                LOP_CLEAR: acc_d[i] = '0;
                LOP_ADD:   acc_d[i] = acc_q[i] + elem[i];
                LOP_FOLD: begin
                    if (HW'(i) < half)
                        acc_d[i] = acc_q[i] + acc_q[IW'(i) + IW'(half)];
                end
                default:   acc_d[i] = acc_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (!rst_n) acc_q[i] <= '0;
            else        acc_q[i] <= acc_d[i];
        end
    end

    assign lane0 = acc_q[0];
endmodule

// File: rtl/vec_tree_reducer.sv
module vec_tree_reducer
    import vtr_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic [LANES*ELEM_W-1:0] in_data,
    output logic                    in_ready,
    output logic                    sum_valid,
    output logic [ELEM_W-1:0]       sum_data
);
    localparam int STEPS = $clog2(LANES);
    localparam int SW    = $clog2(STEPS + 1);

    lane_op_e      lane_op;
    logic [SW-1:0] fold_idx;

    vtr_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .sum_valid (sum_valid),
        .lane_op   (lane_op),
        .fold_idx  (fold_idx)
    );

    vtr_lane_bank #(.LANES(LANES), .ELEM_W(ELEM_W), .SW(SW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_op  (lane_op),
        .fold_idx (fold_idx),
        .chunk    (in_data),
        .lane0    (sum_data)
    );
endmodule

// File: rtl/vtr_checker.sv
module vtr_checker #(
    parameter int LANES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic sum_valid
);
    localparam int STEPS = $clog2(LANES);

    logic       armed;
    logic [7:0] since_last;
    logic       last_acc;

    assign last_acc = in_valid && in_ready && in_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            since_last <= '0;
        end else if (last_acc) begin
            armed      <= 1'b1;
            since_last <= '0;
        end else if (sum_valid) begin
            armed      <= 1'b0;
        end else if (armed && since_last != 8'hFF) begin
            since_last <= since_last + 8'd1;
        end
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (armed && since_last == 8'(STEPS)));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> !sum_valid);

    assert_closed_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_acc |=> !in_ready);

    assert_closed_on_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> !in_ready);

    assert_reopen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> in_ready);
endmodule

bind vec_tree_reducer vtr_checker #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .sum_valid (sum_valid)
);

// File: tb/vec_tree_reducer_tb.sv
module vec_tree_reducer_tb;
    localparam int LANES  = 8;
    localparam int ELEM_W = 32;
    localparam int STEPS  = 3;
    localparam int NVEC   = 8;

    // stimulus table: chunk count, seed, idle cycles between chunks, junk during fold
    localparam int TBL_NCH  [NVEC] = '{1, 2, 3, 4, 1, 5, 2, 3};
    localparam int TBL_SEED [NVEC] = '{7, 100, 3, 55, 1234, 9, 77, 42};
    localparam int TBL_GAP  [NVEC] = '{0, 0, 1, 2, 0, 0, 3, 0};
    localparam bit TBL_JUNK [NVEC] = '{0, 0, 0, 1, 0, 1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic [LANES*ELEM_W-1:0] in_data = '0;
    logic in_ready, sum_valid;
    logic [ELEM_W-1:0] sum_data;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vec_tree_reducer #(.LANES(LANES), .ELEM_W(ELEM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_ready(in_ready), .sum_valid(sum_valid),
        .sum_data(sum_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ELEM_W-1:0] elem_val(input int seed, input int c, input int l);
        logic [31:0] s, k;
        s = 32'(seed);
        k = 32'(c * LANES + l);
        return s * 32'd2654435761 + k * 32'd40503 + (s ^ k);
    endfunction

    // drive one stream, check latency, ready gating and sum
    task automatic run_stream(input int nch, input int seed, input int gap,
                              input bit junk, input bit all_ones);
        logic [ELEM_W-1:0] exp_sum = '0;
        int lat = 0;
        bit closed_ok = 1'b1;
        for (int c = 0; c < nch; c++) begin
            @(negedge clk);
            check(in_ready == 1'b1, "R4 ready before chunk", 32'(in_ready), 32'd1);
            for (int l = 0; l < LANES; l++) begin
                logic [ELEM_W-1:0] v;
                v = all_ones ? '1 : elem_val(seed, c, l);
                in_data[l*ELEM_W +: ELEM_W] = v;
                exp_sum = exp_sum + v;
            end
            in_valid = 1'b1;
            in_last  = (c == nch - 1);
            if (c != nch - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;   // R10 idle cycles
                    in_data  = '1;
                end
            end
        end
        @(negedge clk);
        if (junk) begin
            in_valid = 1'b1;           // R5 chunk offered while closed
            in_last  = 1'b1;
            in_data  = {LANES{32'hDEAD_BEEF}};
        end else begin
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        while (!sum_valid && lat < 50) begin
            if (in_ready) closed_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(closed_ok, "R4 ready low during fold", 32'(closed_ok), 32'd1);
        check(lat == STEPS, "R3 result latency", 32'(lat), 32'(STEPS));
        check(sum_data == exp_sum, junk ? "R5/R2 sum with junk offered" : "R2 stream sum",
              sum_data, exp_sum);
        check(in_ready == 1'b0, "R4 ready low on result", 32'(in_ready), 32'd0);
        @(negedge clk);
        check(sum_valid == 1'b0, "R9 single-cycle pulse", 32'(sum_valid), 32'd0);
        check(in_ready == 1'b1, "R4 ready back after pulse", 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 32'd1);
        check(sum_valid == 1'b0, "R1 no result in reset", 32'(sum_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);

        // table walk; back-to-back streams cover R7, first and fifth rows R6
        for (int v = 0; v < NVEC; v++)
            run_stream(TBL_NCH[v], TBL_SEED[v], TBL_GAP[v], TBL_JUNK[v], 1'b0);

        // R8 wraparound: all-ones elements, 3 chunks -> -24 mod 2^32
        run_stream(3, 0, 0, 1'b0, 1'b1);
        // R6 single chunk wrap
        run_stream(1, 0, 0, 1'b0, 1'b1);

        // R1 reset in the middle of a fold abandons the stream
        @(negedge clk);
        in_data  = {LANES{32'h1111_1111}};
        in_valid = 1'b1;
        in_last  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(in_ready == 1'b1, "R1 ready after mid-fold reset", 32'(in_ready), 32'd1);
        check(sum_valid == 1'b0, "R1 no result after mid-fold reset", 32'(sum_valid), 32'd0);
        for (int w = 0; w < 6; w++) begin
            @(negedge clk);
            check(sum_valid == 1'b0, "R1 abandoned stream gives no result",
                  32'(sum_valid), 32'd0);
        end
        // R7 fresh single-chunk stream must not see leftover sums
        run_stream(1, 321, 0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule